// File: doc/BRIEF.md
# DRAM Powerdown Entry/Exit Sequencer

This controller-side state machine moves a DRAM device with eight banks into and out of a powerdown state in which its clock is stopped. When an entry request arrives, it closes all banks with a precharge-all command. It then refreshes every bank at the current row without moving the row pointer, and holds the command channel silent for a programmable gap. After that it sends the powerdown command. A programmable number of cycles later it raises the enables that allow the clock and the termination supply to be switched off.

A wake request first drops those enables, so that the clock and termination are restored. After a programmable lead time, the block requests a broadcast write on the serial management bus that sets the power-exit bit. Once that write completes, the command channel stays silent for a programmable wake gap. Two refresh bursts follow. The first covers all eight banks and advances the row pointer on its last transaction. The second has a programmed length m and advances the pointer on every eighth transaction, which makes up for the refreshes missed during the wake gap. Each command and the serial write are offered through valid/ready handshakes.

Top module: `pdseq_top`

## Requirements
- R1: After reset, `ready` is 1 and `cmd_valid`, `sbus_valid`, `clk_off_en` and `term_off_en` are all 0.
- R2: A `pd_req` pulse while `ready` is 1 drops `ready` in the next cycle. The first command offered is precharge-all (`cmd_op` 0, `cmd_bank` 0).
- R3: The entry sweep follows the precharge. It is eight non-advancing refreshes (`cmd_op` 1) to banks 0 to 7 in ascending order.
- R4: After the last sweep refresh is accepted, `cmd_valid` stays low for exactly `cfg_quiet` cycles. Then the powerdown command (`cmd_op` 3, bank 0) is offered.
- R5: `clk_off_en` and `term_off_en` rise together `cfg_off_dly`+1 cycles after the cycle in which the powerdown command is accepted. While they are high, nothing is offered on either channel.
- R6: A `wake_req` pulse while powered down clears both enables in the next cycle. `sbus_valid` rises `cfg_restore_lead`+1 cycles after the pulse and carries address 8'h03 and data 8'h01. It is held until `sbus_ready`.
- R7: After the serial write is accepted, `cmd_valid` stays low for exactly `cfg_wake_gap` cycles. Then a refresh to bank 0 is offered.
- R8: The first exit burst is eight refreshes to banks 0 to 7. The first seven use `cmd_op` 1 and the eighth uses the row-advancing refresh, `cmd_op` 2.
- R9: Next come exactly `cfg_extra_refs` refreshes. Their bank cycles from 0, and the op is 2 when the bank is 7 and 1 otherwise. When `cfg_extra_refs` is 0, this burst is skipped.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_bank` hold in the next cycle.
- R11: `ready` stays low until the final exit refresh is accepted. It is 1 in the following cycle.
- R12: `pd_req` has no effect unless `ready` is 1, and `wake_req` has no effect unless the block is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Powerdown entry request pulse |
| wake_req | input | 1 | Powerdown exit request pulse |
| cfg_quiet | input | DLY_W | Silent cycles before the powerdown command |
| cfg_off_dly | input | DLY_W | Cycles from powerdown acceptance to the off enables |
| cfg_restore_lead | input | DLY_W | Cycles from wake to the serial write request |
| cfg_wake_gap | input | DLY_W | Silent cycles after the serial write |
| cfg_extra_refs | input | REFS_W | Length m of the second exit burst |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 2 | 0 precharge-all, 1 refresh, 2 row-advancing refresh, 3 powerdown |
| cmd_bank | output | BANK_W | Target bank of a refresh |
| sbus_valid | output | 1 | Serial broadcast write offered |
| sbus_ready | input | 1 | Serial write complete |
| sbus_addr | output | 8 | Serial register address |
| sbus_data | output | 8 | Serial write data |
| clk_off_en | output | 1 | Clock may be stopped |
| term_off_en | output | 1 | Termination supply may be removed |
| ready | output | 1 | Idle, normal traffic allowed |

## Verification
Every output comes from registered state, so each result is first visible one cycle after the edge that causes it. A programmed delay of d adds exactly d cycles on top of that. Examples: the off enables first show at cfg_off_dly+1 cycles after the powerdown acceptance cycle, and the serial request at cfg_restore_lead+1 cycles after the wake pulse. The bench records, for every cycle, the valid, enable and ready values it samples at the falling edge, and the cycle number of each handshake. It then looks up the first cycle after a given handshake or pulse at which a signal changes, and compares that cycle with the one the requirement predicts. It does not wait by a fixed count.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [1:0] {
        OP_PREA   = 2'd0,
        OP_REF    = 2'd1,
        OP_REFINC = 2'd2,
        OP_PDN    = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLOSE,
        S_SWEEP,
        S_QUIET,
        S_PDN,
        S_OFFWAIT,
        S_SLEEP,
        S_RESTORE,
        S_SBW,
        S_WAKE,
        S_BURST1,
        S_BURST2
    } state_e;

    localparam logic [7:0] SBUS_PM_ADDR = 8'h03;
    localparam logic [7:0] SBUS_PX_DATA = 8'h01;

endpackage

// File: rtl/pdseq_delay.sv
module pdseq_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a wait state loaded with v lasts v cycles: it leaves while the count reads 1
    assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/pdseq_refcnt.sv
module pdseq_refcnt #(
    parameter int NB = 8,
    parameter int CW = 12,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic [BW-1:0] bank,
    output logic          bank_last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    generate
        if ((NB & (NB - 1)) == 0) begin : g_pow2
            assign bank = cnt_q[BW-1:0];
        end else begin : g_wrap
            logic [BW-1:0] bk_d, bk_q;
            always_comb begin
                bk_d = bk_q;
                if (clr)       bk_d = '0;
                else if (step) bk_d = (bk_q == BW'(NB - 1)) ? '0 : bk_q + BW'(1);
            end
            always_ff @(posedge clk) begin
                if (!rst_n) bk_q <= '0;
                else        bk_q <= bk_d;
            end
            assign bank = bk_q;
        end
    endgenerate

    assign bank_last = (bank == BW'(NB - 1));
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
    import pdseq_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int DLY_W     = 16,
    parameter int REFS_W    = 12,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_req,
    input  logic              wake_req,
    input  logic [DLY_W-1:0]  cfg_quiet,
    input  logic [DLY_W-1:0]  cfg_off_dly,
    input  logic [DLY_W-1:0]  cfg_restore_lead,
    input  logic [DLY_W-1:0]  cfg_wake_gap,
    input  logic [REFS_W-1:0] cfg_extra_refs,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              sbus_valid,
    input  logic              sbus_ready,
    output logic [7:0]        sbus_addr,
    output logic [7:0]        sbus_data,
    output logic              clk_off_en,
    output logic              term_off_en,
    output logic              ready
);
    localparam int CW = (REFS_W > BANK_W) ? REFS_W : BANK_W + 1;

    typedef struct packed {
        state_e st;
    } regs_t;

    regs_t r_d, r_q;

    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_last;
    logic             rc_clr;
    logic             rc_step;
    logic [CW-1:0]    rc_count;
    logic [BANK_W-1:0] rc_bank;
    logic             rc_bank_last;
    logic             cmd_hs;
    logic             sbus_hs;
    logic [CW-1:0]    extra_last;

    pdseq_delay #(.W(DLY_W)) i_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .last     (dly_last)
    );

    pdseq_refcnt #(.NB(NUM_BANKS), .CW(CW)) i_refcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rc_clr),
        .step      (rc_step),
        .count     (rc_count),
        .bank      (rc_bank),
        .bank_last (rc_bank_last)
    );

    assign cmd_hs     = cmd_valid && cmd_ready;
    assign sbus_hs    = sbus_valid && sbus_ready;
    assign extra_last = CW'(cfg_extra_refs) - CW'(1);

    always_comb begin
        r_d      = r_q;
        dly_load = 1'b0;
        dly_val  = '0;
        rc_clr   = 1'b0;
        rc_step  = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (pd_req) r_d.st = S_CLOSE;
            end
            S_CLOSE: begin
                if (cmd_hs) begin
                    rc_clr  = 1'b1;
                    r_d.st  = S_SWEEP;
                end
            end
            S_SWEEP: begin
                if (cmd_hs) begin
                    rc_step = 1'b1;
                    if (rc_bank_last) begin
                        if (cfg_quiet == '0) begin
                            r_d.st = S_PDN;
                        end else begin
                            dly_load = 1'b1;
                            dly_val  = cfg_quiet;
                            r_d.st   = S_QUIET;
                        end
                    end
                end
            end
            S_QUIET: begin
                if (dly_last) r_d.st = S_PDN;
            end
            S_PDN: begin
                if (cmd_hs) begin
                    if (cfg_off_dly == '0) begin
                        r_d.st = S_SLEEP;
                    end else begin
                        dly_load = 1'b1;
                        dly_val  = cfg_off_dly;
                        r_d.st   = S_OFFWAIT;
                    end
                end
            end
            S_OFFWAIT: begin
                if (dly_last) r_d.st = S_SLEEP;
            end
            S_SLEEP: begin
                if (wake_req) begin
                    if (cfg_restore_lead == '0) begin
                        r_d.st = S_SBW;
                    end else begin
                        dly_load = 1'b1;
                        dly_val  = cfg_restore_lead;
                        r_d.st   = S_RESTORE;
                    end
                end
            end
            S_RESTORE: begin
                if (dly_last) r_d.st = S_SBW;
            end
            S_SBW: begin
                if (sbus_hs) begin
                    rc_clr = 1'b1;
                    if (cfg_wake_gap == '0) begin
                        r_d.st = S_BURST1;
                    end else begin
                        dly_load = 1'b1;
                        dly_val  = cfg_wake_gap;
                        r_d.st   = S_WAKE;
                    end
                end
            end
            S_WAKE: begin
                if (dly_last) r_d.st = S_BURST1;
            end
            S_BURST1: begin
                if (cmd_hs) begin
                    if (rc_bank_last) begin
                        rc_clr = 1'b1;
                        r_d.st = (cfg_extra_refs == '0) ? S_IDLE : S_BURST2;
                    end else begin
                        rc_step = 1'b1;
                    end
                end
            end
            S_BURST2: begin
                if (cmd_hs) begin
                    rc_step = 1'b1;
                    if (rc_count == extra_last) r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= S_IDLE;
        else        r_q    <= r_d;
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_PREA;
        cmd_bank  = '0;
        unique case (r_q.st)
            S_CLOSE: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_PREA;
            end
            S_SWEEP: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_REF;
                cmd_bank  = rc_bank;
            end
            S_PDN: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_PDN;
            end
            S_BURST1, S_BURST2: begin
                cmd_valid = 1'b1;
                cmd_op    = rc_bank_last ? OP_REFINC : OP_REF;
                cmd_bank  = rc_bank;
            end
            default: ;
        endcase
    end

    assign sbus_valid  = (r_q.st == S_SBW);
    assign sbus_addr   = sbus_valid ? SBUS_PM_ADDR : 8'h00;
    assign sbus_data   = sbus_valid ? SBUS_PX_DATA : 8'h00;
    assign clk_off_en  = (r_q.st == S_SLEEP);
    assign term_off_en = (r_q.st == S_SLEEP);
    assign ready       = (r_q.st == S_IDLE);
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk
    import pdseq_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_req,
    input logic              wake_req,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              sbus_valid,
    input logic              sbus_ready,
    input logic [7:0]        sbus_addr,
    input logic [7:0]        sbus_data,
    input logic              clk_off_en,
    input logic              term_off_en,
    input logic              ready
);
    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank));

    p_sbus_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sbus_valid |-> sbus_addr == 8'h03 && sbus_data == 8'h01);

    p_sbus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sbus_valid && !sbus_ready |=> sbus_valid);

    p_wake_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off_en && wake_req |=> !clk_off_en && !term_off_en);

    p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_off_en || term_off_en) |-> !cmd_valid && !sbus_valid);

    p_entry_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready && pd_req |=> !ready && cmd_valid && cmd_op == 2'd0);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cmd_valid && !sbus_valid && !clk_off_en);

    p_ignore_pd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off_en && pd_req && !wake_req |=> clk_off_en);

    p_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && sbus_valid));
endmodule

bind pdseq_top pdseq_chk #(.BANK_W(BANK_W)) i_pdseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .wake_req    (wake_req),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .sbus_valid  (sbus_valid),
    .sbus_ready  (sbus_ready),
    .sbus_addr   (sbus_addr),
    .sbus_data   (sbus_data),
    .clk_off_en  (clk_off_en),
    .term_off_en (term_off_en),
    .ready       (ready)
);

// File: tb/test_pdseq_top.sv
module test_pdseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int LOGN = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_req = 1'b0;
    logic        wake_req = 1'b0;
    logic [15:0] cfg_quiet = '0;
    logic [15:0] cfg_off_dly = '0;
    logic [15:0] cfg_restore_lead = '0;
    logic [15:0] cfg_wake_gap = '0;
    logic [11:0] cfg_extra_refs = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic        sbus_valid;
    logic        sbus_ready = 1'b0;
    logic [7:0]  sbus_addr;
    logic [7:0]  sbus_data;
    logic        clk_off_en;
    logic        term_off_en;
    logic        ready;

    pdseq_top i_pdseq_top (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
        .cfg_quiet(cfg_quiet), .cfg_off_dly(cfg_off_dly),
        .cfg_restore_lead(cfg_restore_lead), .cfg_wake_gap(cfg_wake_gap),
        .cfg_extra_refs(cfg_extra_refs),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .sbus_valid(sbus_valid), .sbus_ready(sbus_ready),
        .sbus_addr(sbus_addr), .sbus_data(sbus_data),
        .clk_off_en(clk_off_en), .term_off_en(term_off_en), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit bp = 0;
    int swait = 0;
    bit vlog [0:LOGN-1];
    bit elog [0:LOGN-1];
    bit tlog [0:LOGN-1];
    bit rlog [0:LOGN-1];
    bit slog [0:LOGN-1];
    int lop  [0:63];
    int lbk  [0:63];
    int lcyc [0:63];
    int nlog = 0;
    int shs = 0;
    bit prev_stall = 0;
    int prev_op = 0;
    int prev_bk = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one cycle, entered and left at a falling edge
    task automatic step();
        cmd_ready  = bp ? (cyc % 2 == 1) : 1'b1;
        sbus_ready = sbus_valid && (swait >= 2);
        if (cyc < LOGN) begin
            vlog[cyc] = cmd_valid;
            elog[cyc] = clk_off_en;
            tlog[cyc] = term_off_en;
            rlog[cyc] = ready;
            slog[cyc] = sbus_valid;
        end
        if (prev_stall) begin
            // R10 stalled command holds
            chk(cmd_valid && int'(cmd_op) == prev_op && int'(cmd_bank) == prev_bk,
                "R10", "held op", int'(cmd_op), prev_op);
        end
        if (sbus_valid) begin
            chk(sbus_addr == 8'h03 && sbus_data == 8'h01, "R6", "sbus addr/data",
                {sbus_addr, sbus_data}, 16'h0301);
        end
        if (cmd_valid && cmd_ready && nlog < 64) begin
            lop[nlog]  = int'(cmd_op);
            lbk[nlog]  = int'(cmd_bank);
            lcyc[nlog] = cyc;
            nlog++;
        end
        if (sbus_valid && sbus_ready) shs = cyc;
        swait      = sbus_valid ? swait + 1 : 0;
        prev_stall = cmd_valid && !cmd_ready;
        prev_op    = int'(cmd_op);
        prev_bk    = int'(cmd_bank);
        @(negedge clk);
        cyc++;
    endtask

    function automatic int first_high_v(input int from);
        for (int i = from; i < LOGN; i++) if (vlog[i]) return i;
        return -1;
    endfunction
    function automatic int first_high_e(input int from);
        for (int i = from; i < LOGN; i++) if (elog[i]) return i;
        return -1;
    endfunction
    function automatic int first_high_t(input int from);
        for (int i = from; i < LOGN; i++) if (tlog[i]) return i;
        return -1;
    endfunction
    function automatic int first_high_s(input int from);
        for (int i = from; i < LOGN; i++) if (slog[i]) return i;
        return -1;
    endfunction

    task automatic test_reset();
        // R1 reset values
        chk(ready == 1'b1, "R1", "ready", int'(ready), 1);
        chk(!cmd_valid && !sbus_valid, "R1", "valids", int'(cmd_valid) + int'(sbus_valid), 0);
        chk(!clk_off_en && !term_off_en, "R1", "off enables",
            int'(clk_off_en) + int'(term_off_en), 0);
    endtask

    task automatic test_idle_wake_ignored();
        // R12 wake_req while idle
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk(ready && !clk_off_en && !cmd_valid && !sbus_valid, "R12",
            "idle after wake in idle", int'(ready), 1);
        step();
        chk(ready && !sbus_valid, "R12", "still idle", int'(ready), 1);
    endtask

    task automatic run_cycle(input int q, input int o, input int l, input int g,
                             input int m, input bit bpv);
        int pd_c, wk_c, f, last;
        cfg_quiet = 16'(q); cfg_off_dly = 16'(o); cfg_restore_lead = 16'(l);
        cfg_wake_gap = 16'(g); cfg_extra_refs = 12'(m); bp = bpv;
        cyc = 0; nlog = 0; shs = -1; prev_stall = 0;
        pd_c = cyc;
        pd_req = 1'b1;
        step();
        pd_req = 1'b0;
        step();
        pd_req = 1'b1;   // R12 repeated request mid-sweep must not disturb the order
        step();
        pd_req = 1'b0;
        while (!clk_off_en && cyc < 1500) step();
        step();
        pd_req = 1'b1;   // R12 request while powered down
        step();
        pd_req = 1'b0;
        chk(clk_off_en && !cmd_valid, "R12", "enables after pd_req in sleep",
            int'(clk_off_en), 1);
        step();
        wk_c = cyc;
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        while (!ready && cyc < 3000) step();
        step();

        chk(rlog[pd_c] == 1 && rlog[pd_c + 1] == 0, "R2", "ready drop",
            int'(rlog[pd_c + 1]), 0);
        chk(nlog == 18 + m, "R9", "total commands", nlog, 18 + m);
        if (nlog != 18 + m) return;
        chk(lop[0] == 0 && lbk[0] == 0, "R2", "first op precharge", lop[0], 0);
        for (int i = 0; i < NB; i++) begin
            chk(lop[1 + i] == 1 && lbk[1 + i] == i, "R3", "sweep op*8+bank",
                lop[1 + i] * 8 + lbk[1 + i], 8 + i);
        end
        chk(lop[9] == 3, "R4", "powerdown op", lop[9], 3);
        f = first_high_v(lcyc[8] + 1);
        chk(f == lcyc[8] + q + 1, "R4", "powerdown offer cycle", f, lcyc[8] + q + 1);
        f = first_high_e(lcyc[9] + 1);
        chk(f == lcyc[9] + o + 1, "R5", "clk off cycle", f, lcyc[9] + o + 1);
        f = first_high_t(lcyc[9] + 1);
        chk(f == lcyc[9] + o + 1, "R5", "term off cycle", f, lcyc[9] + o + 1);
        chk(elog[wk_c] == 1 && elog[wk_c + 1] == 0 && tlog[wk_c + 1] == 0, "R6",
            "enables after wake", int'(elog[wk_c + 1]), 0);
        f = first_high_s(wk_c + 1);
        chk(f == wk_c + l + 1, "R6", "serial request cycle", f, wk_c + l + 1);
        f = first_high_v(shs + 1);
        chk(shs >= 0 && f == shs + g + 1, "R7", "first exit refresh cycle", f, shs + g + 1);
        chk(lop[10] == 1 && lbk[10] == 0, "R7", "first exit op", lop[10], 1);
        for (int i = 0; i < NB; i++) begin
            chk(lop[10 + i] == (i == NB - 1 ? 2 : 1) && lbk[10 + i] == i, "R8",
                "burst1 op*8+bank", lop[10 + i] * 8 + lbk[10 + i],
                (i == NB - 1 ? 2 : 1) * 8 + i);
        end
        for (int j = 0; j < m; j++) begin
            chk(lop[18 + j] == ((j % NB) == NB - 1 ? 2 : 1) && lbk[18 + j] == j % NB, "R9",
                "burst2 op*8+bank", lop[18 + j] * 8 + lbk[18 + j],
                ((j % NB) == NB - 1 ? 2 : 1) * 8 + j % NB);
        end
        last = lcyc[nlog - 1];
        chk(rlog[last] == 0 && rlog[last + 1] == 1, "R11", "ready after final refresh",
            int'(rlog[last + 1]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_wake_ignored();
        run_cycle(3, 2, 4, 5, 11, 1'b0);
        run_cycle(0, 0, 0, 0, 0, 1'b1);
        run_cycle(1, 6, 2, 3, 16, 1'b1);
        run_cycle(7, 1, 9, 12, 8, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule